// File: doc/BRIEF.md
# Reconfigurable Synapse-Row to Neuron Event Router

This block sits between a bank of synapse rows and a bank of integrating neurons. Every incoming event carries the index of the synapse row that fired, a two-bit synapse kind and a digital weight. The block looks up that row in a small configuration table and re-emits the event addressed to the neuron the row is currently wired to. The kind and the weight pass through unchanged.

In the reset configuration each row feeds the neuron with the same index. Loading the table lets several rows share one neuron, which raises that neuron's fan-in and leaves other neurons without any input. At the far end, every row can point at a single neuron. A row can also be cut off completely, and events arriving from it are then absorbed. A per-neuron enable vector tells downstream logic which neurons still receive at least one connected row.

Events enter and leave through valid/ready handshakes with one register stage in between. When the consumer holds off, the router stops taking input. The table is loaded one row per cycle through a write strobe.

Top module: `rowmerge_router`

## Requirements
- R1: While `rst_n` is low and right after its release, row r maps to neuron r with every row connected, `nrn_en` is all ones, `out_valid` is 0 and `in_ready` is 1.
- R2: An event accepted from a connected row (`in_valid` and `in_ready` high at a clock edge) appears on the output on the next cycle: `out_valid` is 1, `out_neuron` is the row's table target, and `out_kind` and `out_weight` equal the accepted values.
- R3: An event accepted from a disconnected row is consumed with no output event. If nothing else is loaded, `out_valid` is 0 on the next cycle.
- R4: A table write (`cfg_we` with `cfg_row`, `cfg_target`, `cfg_cut` where `cfg_cut`=1 means disconnected) affects only events accepted at later edges. An event accepted at the same edge as a write to its row uses the old entry.
- R5: `nrn_en[n]` is 1 exactly when at least one connected row has target n. It reflects a table write from the cycle after that write's clock edge.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_neuron`, `out_kind` and `out_weight` hold steady.
- R7: `in_ready` is 1 whenever the output register is empty or is being drained in the same cycle, so one event per cycle passes when `out_ready` stays high.
- R8: With all rows mapped to one neuron t, `nrn_en` has only bit t set and every event from any row leaves addressed to t.
- R9: After an output handshake with no new connected event accepted at that edge, `out_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_row | input | ROW_W (5) | Row whose entry is written |
| cfg_target | input | NRN_W (5) | New target neuron for that row |
| cfg_cut | input | 1 | 1 disconnects the row, 0 connects it |
| in_valid | input | 1 | Input event present |
| in_ready | output | 1 | Router takes the input event this cycle |
| in_row | input | ROW_W (5) | Source synapse row |
| in_kind | input | 2 | Synapse kind (two excitatory, two inhibitory codes) |
| in_weight | input | WEIGHT_W (5) | Synaptic weight |
| out_valid | output | 1 | Routed event present |
| out_ready | input | 1 | Consumer takes the routed event |
| out_neuron | output | NRN_W (5) | Target neuron |
| out_kind | output | 2 | Synapse kind, passed through |
| out_weight | output | WEIGHT_W (5) | Weight, passed through |
| nrn_en | output | NUM_NEURONS (32) | Neurons fed by at least one connected row |

## Verification
The properties assume that the row and neuron counts are powers of two, so that every `in_row` and `cfg_row` value names a real row. They place no holding rule on `in_valid`: an offered event counts only at an edge where `in_ready` is high, and `out_ready` may toggle freely. The stimulus draws rows, kinds and weights from a pseudo-random generator across the full code range. It toggles `out_ready` in both bursty and random patterns, and it places table writes in the same cycles as events so the old-entry rule is exercised. All inputs change half a cycle away from the sampling edge.

// File: rtl/dmr_pkg.sv
// Package: shared widths and codes for the row-to-neuron router.
// Assumes: four synapse kinds, encoded on two bits.
package dmr_pkg;
    localparam int SYN_W = 2;

    // Synapse kind codes carried with every event (passed through untouched).
    typedef enum logic [SYN_W-1:0] {
        SYN_EXC_FAST = 2'd0,
        SYN_EXC_SLOW = 2'd1,
        SYN_INH_FAST = 2'd2,
        SYN_INH_SLOW = 2'd3
    } syn_kind_e;
endpackage

// File: rtl/route_table.sv
// Module: route_table
// Holds one target-neuron index and one disconnect flag per synapse row.
// Offers a combinational lookup for the incoming row and a flat copy of the
// whole table for the enable-mask logic.
// Assumes: NUM_ROWS is a power of two (every row code is valid) and
// NUM_NEURONS >= 1; the reset map is row r -> neuron r mod NUM_NEURONS.
module route_table #(
    parameter int NUM_ROWS    = 32,
    parameter int NUM_NEURONS = 32,
    parameter int ROW_W       = $clog2(NUM_ROWS),
    parameter int NRN_W       = $clog2(NUM_NEURONS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ROW_W-1:0]          wr_row,
    input  logic [NRN_W-1:0]          wr_target,
    input  logic                      wr_cut,
    input  logic [ROW_W-1:0]          rd_row,
    output logic [NRN_W-1:0]          rd_target,
    output logic                      rd_cut,
    output logic [NUM_ROWS*NRN_W-1:0] tgt_flat,
    output logic [NUM_ROWS-1:0]       cut_vec
);
    logic [NRN_W-1:0] tgt_q [NUM_ROWS];
    logic             cut_q [NUM_ROWS];

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        localparam logic [NRN_W-1:0] RST_TGT = NRN_W'(r % NUM_NEURONS);
        logic hit;

        // Decode: this row is the one being written.
        always_comb hit = wr_en && (wr_row == ROW_W'(r));

        // Entry storage: identity map and connected on reset, loaded on write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tgt_q[r] <= RST_TGT;
                cut_q[r] <= 1'b0;
            end else if (hit) begin
                tgt_q[r] <= wr_target;
                cut_q[r] <= wr_cut;
            end
        end

        // Flatten the entry for the mask builder.
        always_comb begin
            tgt_flat[r*NRN_W +: NRN_W] = tgt_q[r];
            cut_vec[r]                 = cut_q[r];
        end
    end

    // Lookup of the entry for the row presented at the input.
    always_comb begin
        rd_target = tgt_q[rd_row];
        rd_cut    = cut_q[rd_row];
    end
endmodule

// File: rtl/nrn_mask_gen.sv
// Module: nrn_mask_gen
// Derives, for every neuron, whether any connected row currently targets it.
// Purely combinational, so the mask follows the table with no extra delay.
// Assumes: tgt_flat packs NUM_ROWS entries of NRN_W bits, row 0 lowest.
module nrn_mask_gen #(
    parameter int NUM_ROWS    = 32,
    parameter int NUM_NEURONS = 32,
    parameter int NRN_W       = $clog2(NUM_NEURONS)
) (
    input  logic [NUM_ROWS*NRN_W-1:0] tgt_flat,
    input  logic [NUM_ROWS-1:0]       cut_vec,
    output logic [NUM_NEURONS-1:0]    nrn_en
);
    for (genvar n = 0; n < NUM_NEURONS; n++) begin : g_nrn
        logic hit;

        // OR over all rows whose target equals this neuron and that are connected.
        always_comb begin
            hit = 1'b0;
            for (int r = 0; r < NUM_ROWS; r++) begin
                if (!cut_vec[r] && (tgt_flat[r*NRN_W +: NRN_W] == NRN_W'(n)))
                    hit = 1'b1;
            end
        end

        // Drive this neuron's enable bit.
        always_comb nrn_en[n] = hit;
    end
endmodule

// File: rtl/route_stage.sv
// Module: route_stage
// Single output register with valid/ready on both sides. An accepted event
// flagged as dropped is consumed without loading the register.
// Assumes: the upstream side may withdraw in_valid at any time; only the
// cycle with in_valid && in_ready counts as a transfer.
module route_stage #(
    parameter int NRN_W    = 5,
    parameter int KIND_W   = 2,
    parameter int WEIGHT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_drop,
    input  logic [NRN_W-1:0]    in_neuron,
    input  logic [KIND_W-1:0]   in_kind,
    input  logic [WEIGHT_W-1:0] in_weight,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [NRN_W-1:0]    out_neuron,
    output logic [KIND_W-1:0]   out_kind,
    output logic [WEIGHT_W-1:0] out_weight
);
    logic take;
    logic load;

    // Ready when the register is empty or empties this cycle.
    always_comb in_ready = !out_valid || out_ready;

    // Transfer qualifiers: take consumes, load also fills the register.
    always_comb begin
        take = in_valid && in_ready;
        load = take && !in_drop;
    end

    // Valid flag: set on load, cleared when drained without a refill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (load)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    // Payload register: captured only on a loading transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_neuron <= '0;
            out_kind   <= '0;
            out_weight <= '0;
        end else if (load) begin
            out_neuron <= in_neuron;
            out_kind   <= in_kind;
            out_weight <= in_weight;
        end
    end
endmodule

// File: rtl/rowmerge_router.sv
// Module: rowmerge_router (top)
// Routes synapse-row events to neurons through a loadable row->neuron table,
// drops events from disconnected rows and publishes which neurons are fed.
// Assumes: NUM_ROWS and NUM_NEURONS are powers of two; table writes and
// event lookups in the same cycle see the table as it was before the edge.
module rowmerge_router #(
    parameter int NUM_ROWS    = 32,
    parameter int NUM_NEURONS = 32,
    parameter int WEIGHT_W    = 5,
    localparam int ROW_W      = $clog2(NUM_ROWS),
    localparam int NRN_W      = $clog2(NUM_NEURONS),
    localparam int KIND_W     = dmr_pkg::SYN_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ROW_W-1:0]       cfg_row,
    input  logic [NRN_W-1:0]       cfg_target,
    input  logic                   cfg_cut,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [ROW_W-1:0]       in_row,
    input  logic [KIND_W-1:0]      in_kind,
    input  logic [WEIGHT_W-1:0]    in_weight,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [NRN_W-1:0]       out_neuron,
    output logic [KIND_W-1:0]      out_kind,
    output logic [WEIGHT_W-1:0]    out_weight,
    output logic [NUM_NEURONS-1:0] nrn_en
);
    logic [NRN_W-1:0]          lk_target;
    logic                      lk_cut;
    logic [NUM_ROWS*NRN_W-1:0] tgt_flat;
    logic [NUM_ROWS-1:0]       cut_vec;

    route_table #(
        .NUM_ROWS   (NUM_ROWS),
        .NUM_NEURONS(NUM_NEURONS),
        .ROW_W      (ROW_W),
        .NRN_W      (NRN_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_row   (cfg_row),
        .wr_target(cfg_target),
        .wr_cut   (cfg_cut),
        .rd_row   (in_row),
        .rd_target(lk_target),
        .rd_cut   (lk_cut),
        .tgt_flat (tgt_flat),
        .cut_vec  (cut_vec)
    );

    nrn_mask_gen #(
        .NUM_ROWS   (NUM_ROWS),
        .NUM_NEURONS(NUM_NEURONS),
        .NRN_W      (NRN_W)
    ) u_mask (
        .tgt_flat(tgt_flat),
        .cut_vec (cut_vec),
        .nrn_en  (nrn_en)
    );

    route_stage #(
        .NRN_W   (NRN_W),
        .KIND_W  (KIND_W),
        .WEIGHT_W(WEIGHT_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_drop   (lk_cut),
        .in_neuron (lk_target),
        .in_kind   (in_kind),
        .in_weight (in_weight),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_neuron(out_neuron),
        .out_kind  (out_kind),
        .out_weight(out_weight)
    );
endmodule

// File: rtl/rowmerge_router_chk.sv
// Module: rowmerge_router_chk
// Temporal properties of the router, attached to the top by bind. Watches the
// table lookup and the output stage as separately driven pieces.
// Assumes: synchronous active-low reset; all properties disabled during it.
module rowmerge_router_chk #(
    parameter int NRN_W    = 5,
    parameter int KIND_W   = 2,
    parameter int WEIGHT_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [KIND_W-1:0]   in_kind,
    input logic [WEIGHT_W-1:0] in_weight,
    input logic [NRN_W-1:0]    lk_target,
    input logic                lk_cut,
    input logic                out_valid,
    input logic                out_ready,
    input logic [NRN_W-1:0]    out_neuron,
    input logic [KIND_W-1:0]   out_kind,
    input logic [WEIGHT_W-1:0] out_weight
);
    // R2: connected transfer shows up next cycle with the looked-up target.
    a_r2_routed_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !lk_cut) |=>
            (out_valid && out_neuron == $past(lk_target)
             && out_kind == $past(in_kind) && out_weight == $past(in_weight)));

    // R3: a transfer from a cut row never refills an empty output.
    a_r3_cut_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && lk_cut) |=> !out_valid);

    // R6: stalled output keeps its payload and blocks the input.
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_neuron) && $stable(out_kind) && $stable(out_weight)));

    a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R9: drained with nothing new taken leaves the output empty.
    a_r9_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);
endmodule

bind rowmerge_router rowmerge_router_chk #(
    .NRN_W   (NRN_W),
    .KIND_W  (KIND_W),
    .WEIGHT_W(WEIGHT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_kind   (in_kind),
    .in_weight (in_weight),
    .lk_target (lk_target),
    .lk_cut    (lk_cut),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_neuron(out_neuron),
    .out_kind  (out_kind),
    .out_weight(out_weight)
);

// File: tb/sim_rowmerge_router.sv
module sim_rowmerge_router;
    localparam int NR = 32;
    localparam int NN = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_row = '0;
    logic [4:0]  cfg_target = '0;
    logic        cfg_cut = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  in_row = '0;
    logic [1:0]  in_kind = '0;
    logic [4:0]  in_weight = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [4:0]  out_neuron;
    logic [1:0]  out_kind;
    logic [4:0]  out_weight;
    logic [31:0] nrn_en;

    rowmerge_router u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_target(cfg_target), .cfg_cut(cfg_cut),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
        .in_kind(in_kind), .in_weight(in_weight),
        .out_valid(out_valid), .out_ready(out_ready), .out_neuron(out_neuron),
        .out_kind(out_kind), .out_weight(out_weight), .nrn_en(nrn_en)
    );

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    // Reference model state
    int   m_tgt [NR];
    bit   m_cut [NR];
    bit   e_valid;
    int   e_neuron, e_kind, e_weight;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_mask();
        logic [31:0] m = '0;
        for (int r = 0; r < NR; r++)
            if (!m_cut[r]) m[m_tgt[r]] = 1'b1;
        return m;
    endfunction

    // Model update at each edge: route with the old table, then apply the write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NR; r++) begin m_tgt[r] = r; m_cut[r] = 0; end
            e_valid = 0;
        end else begin
            if (in_valid && (!e_valid || out_ready) && !m_cut[in_row]) begin
                e_valid = 1; e_neuron = m_tgt[in_row]; e_kind = in_kind; e_weight = in_weight;
            end else if (out_ready) begin
                e_valid = 0;
            end
            if (cfg_we) begin m_tgt[cfg_row] = cfg_target; m_cut[cfg_row] = cfg_cut; end
        end
    end

    // Per-cycle comparison, a quarter period after the falling edge.
    always @(negedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk(out_valid == e_valid, "R3/R9 out_valid", 32'(out_valid), 32'(e_valid));
            chk(in_ready == (!e_valid || out_ready), "R7 in_ready", 32'(in_ready), 32'(!e_valid || out_ready));
            chk(nrn_en == model_mask(), "R5 nrn_en", nrn_en, model_mask());
            if (e_valid && out_valid)
                chk(out_neuron == e_neuron && out_kind == e_kind && out_weight == e_weight,
                    "R2 payload", {17'd0, out_kind, out_weight, 3'd0, out_neuron},
                    32'({e_kind[1:0], e_weight[4:0], 3'd0, e_neuron[4:0]}));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1; checks++; failures++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    task automatic cfg(input int row, input int tgt, input bit cut);
        @(negedge clk);
        in_valid = 0; cfg_we = 1; cfg_row = 5'(row); cfg_target = 5'(tgt); cfg_cut = cut;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Random traffic; mode 0 ready always, 1 random ready, 2 bursty ready.
    task automatic traffic(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step();
            in_valid  = lfsr[0] | lfsr[1];
            in_row    = lfsr[8:4];
            in_kind   = lfsr[10:9];
            in_weight = lfsr[15:11];
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[20] : ((i % 8) < 5);
            cfg_we    = 0;
        end
        @(negedge clk);
        in_valid = 0; out_ready = 1;
    endtask

    logic [4:0] held_n;
    logic [4:0] held_w;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #5;
        chk(nrn_en == 32'hFFFF_FFFF, "R1 reset mask", nrn_en, 32'hFFFF_FFFF);
        chk(out_valid == 0, "R1 reset out_valid", 32'(out_valid), 0);
        chk(in_ready == 1, "R1 reset in_ready", 32'(in_ready), 1);

        // R1/R2: identity routing, several ready patterns
        traffic(300, 0);
        traffic(300, 1);
        traffic(300, 2);

        // R3/R5: cut rows and a remap
        cfg(3, 3, 1);
        cfg(7, 7, 1);
        cfg(5, 9, 0);
        #5;
        chk(nrn_en[3] == 0 && nrn_en[7] == 0 && nrn_en[5] == 0 && nrn_en[9] == 1,
            "R5 mask after remap", {nrn_en[9], nrn_en[7], nrn_en[5], nrn_en[3]}, 32'b1000);
        @(negedge clk);
        in_valid = 1; in_row = 3; in_kind = 1; in_weight = 5'd21; out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        #5;
        chk(out_valid == 0, "R3 cut row dropped", 32'(out_valid), 0);
        traffic(400, 1);

        // R4: write and event to the same row at one edge
        @(negedge clk);
        cfg_we = 1; cfg_row = 10; cfg_target = 20; cfg_cut = 0;
        in_valid = 1; in_row = 10; in_kind = 2; in_weight = 5'd7; out_ready = 1;
        @(negedge clk);
        cfg_we = 0; in_row = 10; in_weight = 5'd8;
        #5;
        chk(out_neuron == 10, "R4 old entry used", 32'(out_neuron), 10);
        @(negedge clk);
        in_valid = 0;
        #5;
        chk(out_neuron == 20, "R4 new entry used", 32'(out_neuron), 20);

        // R6: stall with input offered
        @(negedge clk);
        in_valid = 1; in_row = 2; in_kind = 3; in_weight = 5'd19; out_ready = 0;
        @(negedge clk);
        in_row = 4; in_weight = 5'd1;
        #5;
        held_n = out_neuron; held_w = out_weight;
        repeat (4) @(negedge clk);
        #5;
        chk(out_neuron == held_n && out_weight == held_w && !in_ready, "R6 stall hold",
            {22'd0, in_ready, held_w, out_neuron}, {23'd0, held_w, held_n});
        @(negedge clk);
        in_valid = 0; out_ready = 1;

        // R8: full merge onto neuron 17
        for (int r = 0; r < NR; r++) cfg(r, 17, 0);
        #5;
        chk(nrn_en == 32'h0002_0000, "R8 merged mask", nrn_en, 32'h0002_0000);
        traffic(400, 2);
        @(negedge clk);
        in_valid = 1; in_row = 31; in_kind = 0; in_weight = 5'd31;
        @(negedge clk);
        in_valid = 0;
        #5;
        chk(out_valid && out_neuron == 17, "R8 merged target", 32'(out_neuron), 17);

        // R5: all rows cut -> empty mask; then reconnect one
        for (int r = 0; r < NR; r++) cfg(r, r, 1);
        #5;
        chk(nrn_en == 0, "R5 all cut", nrn_en, 0);
        traffic(200, 1);
        cfg(12, 0, 0);
        traffic(200, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule